// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital half of a serial 8-bit successive-approximation converter. A host talks to it over four wires: an active-low chip select, a serial clock, a data input and a data output. Once selected, the block looks for a start bit on the data input, takes in a 4-bit channel assignment word, waits half a serial clock for the analog selection to settle, and then runs eight approximation steps. In each step it puts a trial code on a parallel port towards an external comparator and reads back a one-bit decision. The decisions are sent out most-significant bit first while they are made, and the stored result is then sent again least-significant bit first. A busy flag marks the conversion.

The serial clock, chip select and data input are sampled by a faster system clock. A serial edge counts when the system clock first sees the new level, and every output changes on that same system clock edge. The output pins that would float when the block is deselected are each given as a value and an enable. The resistor ladder, the comparator and the channel switches are outside the block. The decoded assignment word is provided as a registered output so that the surrounding analog logic can act on it.

Top module: `sar_serial_frontend`

## Requirements
- R1: While `cs_n` is high, `do_oe`, `busy_oe`, `busy`, `do_data`, `word_vld`, `assign_word` and `trial_code` are all 0, from the system clock after `cs_n` is seen high. A new frame starts from a cleared state, even if the previous frame was aborted.
- R2: With `cs_n` low, `di` is sampled at each rising `sclk` edge. Zeros are skipped. The first 1 is the start bit.
- R3: The next four sampled bits form `assign_word`. The first of them lands in bit 3 (single-ended/differential), then bit 2 (odd/sign), bit 1 and bit 0 (channel select). `word_vld` goes to 1 at the rising edge that takes in the last bit and stays there until `cs_n` goes high.
- R4: At the first falling `sclk` edge after the word is complete, `busy` and `do_oe` go to 1 and `do_data` shows a leading 0 for that serial period. From the last word bit on, `di` no longer has any effect.
- R5: During approximation step k (k = 0..7), `trial_code` holds the bits already accepted with bit 7-k also set. The bit is kept when `cmp_in` is 1 at the falling edge that ends the step. After the last step, `trial_code` holds the final result.
- R6: At each of the 8 falling edges that follow the leading zero, `do_data` presents the decision just made: bit 7 first, down to bit 0.
- R7: `busy` returns to 0 at the first rising edge after the eighth decision. `busy_oe` is 1 whenever `cs_n` is low.
- R8: At the next 7 falling edges, `do_data` presents result bits 1 up to 7 (bit 0 was the last bit of the first stream). From the falling edge after that, `do_data` stays 0 until `cs_n` goes high.
- R9: When the comparator never reports at-or-above (positive input below negative input), the result is 0x00 and both streams are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in (start bit and assignment word) |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Serial data out drive enable |
| busy | output | 1 | Conversion in progress value |
| busy_oe | output | 1 | Busy pin drive enable |
| trial_code | output | RES_W | Trial level towards the external comparator |
| cmp_in | input | 1 | Comparator decision: 1 = input at or above the trial level |
| assign_word | output | WORD_W | Captured channel assignment word |
| word_vld | output | 1 | Assignment word complete and held |

## Verification
On every cycle, the assertions check these rules: all outputs are released one clock after deselection, `busy` never shows without the data output enabled, the enable comes up together with busy and a zero, `do_data` changes only on falling serial edges, `busy` falls only on a rising edge, and the assignment word holds steady once it is valid. Other behaviour only shows in the bench's frames: whether the start bit is found after a varying number of leading zeros, whether each trial code and decision matches the stimulus level, the exact order of the two result streams, the all-zero result for a negative differential input, and a frame aborted mid-conversion followed by a clean one.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

    // Frame sequencing states.
    typedef enum logic [2:0] {
        ST_HUNT = 3'd0,  // waiting for the start bit
        ST_ADDR = 3'd1,  // shifting in the assignment word
        ST_GAP  = 3'd2,  // half-period settle, waiting for falling edge
        ST_CONV = 3'd3,  // approximation steps, MSB-first stream
        ST_LSB  = 3'd4,  // replaying the result LSB first
        ST_HOLD = 3'd5   // output held low until deselect
    } seq_e;

    // Serial clock edge events, one system clock wide.
    typedef struct packed {
        logic rise;
        logic fall;
    } sedge_t;

    function automatic logic word_phase(input seq_e st);
        return (st == ST_GAP) || (st == ST_CONV) || (st == ST_LSB) || (st == ST_HOLD);
    endfunction

endpackage

// File: rtl/ssf_edge.sv
module ssf_edge
    import ssf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk,
    output sedge_t edg
);

    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    always_comb begin
        edg.rise = sclk & ~sclk_q;
        edg.fall = ~sclk & sclk_q;
    end

endmodule

// File: rtl/ssf_ctrl.sv
module ssf_ctrl
    import ssf_pkg::*;
#(
    parameter int WORD_W = 4,
    parameter int RES_W  = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              di,
    input  sedge_t            edg,
    output seq_e              state,
    output logic [CNT_W-1:0]  cnt,
    output logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              do_oe,
    output logic              cs_act
);

    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] RES_LAST  = CNT_W'(RES_W - 1);

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            word   <= '0;
            busy   <= 1'b0;
            do_oe  <= 1'b0;
            cs_act <= 1'b0;
        end else begin
            cs_act <= 1'b1;
            unique case (state)
                ST_HUNT: begin
                    if (edg.rise && di) begin
                        state <= ST_ADDR;
                        cnt   <= '0;
                    end
                end
                ST_ADDR: begin
                    if (edg.rise) begin
                        word <= {word[WORD_W-2:0], di};
                        if (cnt == WORD_LAST) begin
                            state <= ST_GAP;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (edg.fall) begin
                        state <= ST_CONV;
                        cnt   <= '0;
                        busy  <= 1'b1;
                        do_oe <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (edg.fall) begin
                        if (cnt == RES_LAST) begin
                            state <= ST_LSB;
                            cnt   <= CNT_W'(1);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_LSB: begin
                    if (edg.fall) begin
                        if (cnt == RES_LAST) state <= ST_HOLD;
                        else                 cnt   <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
            // Busy drops on the first rising edge after the last decision.
            if (edg.rise && busy && (state != ST_CONV))
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/ssf_sar.sv
module ssf_sar
    import ssf_pkg::*;
#(
    parameter int RES_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  seq_e             state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             fall,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic             do_bit
);

    localparam logic [RES_W-1:0] ONE = RES_W'(1);

    logic [RES_W-1:0] res;
    logic [RES_W-1:0] mask;

    always_comb begin
        mask = '0;
        if (state == ST_CONV)
            mask = ONE << (RES_W - 1 - int'(cnt));
        trial = res | mask;
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            res    <= '0;
            do_bit <= 1'b0;
        end else if (fall) begin
            unique case (state)
                ST_GAP:  do_bit <= 1'b0;
                ST_CONV: begin
                    if (cmp_in) res <= res | mask;
                    do_bit <= cmp_in;
                end
                ST_LSB:  do_bit <= res[cnt];
                ST_HOLD: do_bit <= 1'b0;
                default: do_bit <= do_bit;
            endcase
        end
    end

endmodule

// File: rtl/sar_serial_frontend.sv
module sar_serial_frontend
    import ssf_pkg::*;
#(
    parameter int RES_W  = 8,
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              di,
    output logic              do_data,
    output logic              do_oe,
    output logic              busy,
    output logic              busy_oe,
    output logic [RES_W-1:0]  trial_code,
    input  logic              cmp_in,
    output logic [WORD_W-1:0] assign_word,
    output logic              word_vld
);

    localparam int CNT_MAX = (RES_W > WORD_W) ? RES_W : WORD_W;
    localparam int CNT_W   = $clog2(CNT_MAX);

    sedge_t           edg;
    seq_e             state;
    logic [CNT_W-1:0] cnt;
    logic             cs_act;

    ssf_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .edg  (edg)
    );

    ssf_ctrl #(
        .WORD_W (WORD_W),
        .RES_W  (RES_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .di     (di),
        .edg    (edg),
        .state  (state),
        .cnt    (cnt),
        .word   (assign_word),
        .busy   (busy),
        .do_oe  (do_oe),
        .cs_act (cs_act)
    );

    ssf_sar #(
        .RES_W (RES_W),
        .CNT_W (CNT_W)
    ) u_sar (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .state  (state),
        .cnt    (cnt),
        .fall   (edg.fall),
        .cmp_in (cmp_in),
        .trial  (trial_code),
        .do_bit (do_data)
    );

    assign busy_oe  = cs_act;
    assign word_vld = word_phase(state);

endmodule

// File: rtl/ssf_chk.sv
module ssf_chk #(
    parameter int WORD_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sclk,
    input logic              do_data,
    input logic              do_oe,
    input logic              busy,
    input logic              busy_oe,
    input logic [WORD_W-1:0] assign_word,
    input logic              word_vld
);

    // R1: outputs released one clock after deselect
    a_r1_release_on_deselect: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!do_oe && !busy_oe && !word_vld));

    // R4: busy never shown without the data output enabled
    a_r4_busy_needs_oe: assert property (@(posedge clk) disable iff (rst)
        busy |-> do_oe);

    // R4: data output enable comes up together with busy and a leading zero
    a_r4_enable_with_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(do_oe) |-> (busy && !do_data));

    // R6: driven data changes only after a falling serial edge
    a_r6_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        (do_oe && $past(do_oe) && (do_data != $past(do_data)))
            |-> (!$past(sclk) && !$past(cs_n)));

    // R7: busy falls on a rising serial edge while still selected
    a_r7_busy_drop_on_rise: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(cs_n) && !$past(rst)) |-> $past(sclk));

    // R3: assignment word holds while valid
    a_r3_word_stable: assert property (@(posedge clk) disable iff (rst)
        (word_vld && $past(word_vld)) |-> $stable(assign_word));

endmodule

bind sar_serial_frontend ssf_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .do_data     (do_data),
    .do_oe       (do_oe),
    .busy        (busy),
    .busy_oe     (busy_oe),
    .assign_word (assign_word),
    .word_vld    (word_vld)
);

// File: tb/sar_serial_frontend_tb.sv
module sar_serial_frontend_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       di = 1'b0;
    logic       do_data, do_oe, busy, busy_oe, word_vld, cmp_in;
    logic [7:0] trial_code;
    logic [3:0] assign_word;

    logic [7:0] stim = 8'h00;
    logic       neg_mode = 1'b0;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    // External comparator model.
    assign cmp_in = neg_mode ? 1'b0 : (stim >= trial_code);

    sar_serial_frontend u_dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .di (di),
        .do_data (do_data), .do_oe (do_oe), .busy (busy), .busy_oe (busy_oe),
        .trial_code (trial_code), .cmp_in (cmp_in),
        .assign_word (assign_word), .word_vld (word_vld)
    );

    // Behavioural reference state.
    bit         m_sel, m_started, m_busy, m_oe, m_do, m_wvld;
    int         m_nbits, m_falls;
    logic [3:0] m_word;
    logic [7:0] m_res;
    bit         q_do[$];

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_trial();
        int d;
        logic [7:0] hi;
        if (!m_oe) return 8'h00;
        d = m_falls - 1;
        if (d >= 8) return m_res;
        hi = (d == 0) ? 8'h00 : (8'hFF << (8 - d));
        return (m_res & hi) | (8'h80 >> d);
    endfunction

    task automatic compare_all();
        chk(do_oe,    m_oe,  cs_n ? "R1 do_oe" : "R4 do_oe");
        chk(busy_oe,  m_sel, cs_n ? "R1 busy_oe" : "R7 busy_oe");
        chk(busy,     m_busy, "R7 busy");
        chk(do_data,  m_do,  neg_mode ? "R9 do_data" : "R6/R8 do_data");
        chk(trial_code, exp_trial(), "R5 trial_code");
        chk(assign_word, m_word, "R3 assign_word");
        chk(word_vld, m_wvld, "R3 word_vld");
    endtask

    task automatic model_clear();
        m_sel = 0; m_started = 0; m_busy = 0; m_oe = 0; m_do = 0; m_wvld = 0;
        m_nbits = 0; m_falls = 0; m_word = '0; m_res = '0;
        q_do.delete();
    endtask

    // One system clock: check at the falling clk edge, then drive.
    task automatic step(input logic c, input logic s, input logic d);
        logic pc, ps;
        @(negedge clk);
        if (!rst) compare_all();
        pc = cs_n; ps = sclk;
        cs_n = c; sclk = s; di = d;
        if (c) model_clear();
        else begin
            if (pc) m_sel = 1;
            if (!ps && s) begin
                if (!m_started) begin
                    if (d) m_started = 1;
                end else if (m_nbits < 4) begin
                    m_word = {m_word[2:0], d};
                    m_nbits++;
                    if (m_nbits == 4) m_wvld = 1;
                end
                if (m_busy && m_falls >= 9) m_busy = 0;
            end
            if (ps && !s && m_nbits == 4) begin
                if (!m_oe) begin
                    m_oe = 1; m_busy = 1; m_do = 0; m_falls = 1;
                    m_res = neg_mode ? 8'h00 : stim;
                    for (int i = 7; i >= 0; i--) q_do.push_back(m_res[i]);
                    for (int i = 1; i <= 7; i++) q_do.push_back(m_res[i]);
                end else begin
                    m_do = (q_do.size() > 0) ? q_do.pop_front() : 1'b0;
                    m_falls++;
                end
            end
        end
    endtask

    task automatic sclk_bit(input logic d);
        repeat (4) step(1'b0, 1'b1, d);
        repeat (4) step(1'b0, 1'b0, d);
    endtask

    // A frame: leading zeros, start bit, word, then 'periods' serial periods
    // with DI toggling (must be ignored).
    task automatic frame(input int zeros, input logic [3:0] w, input logic [7:0] s,
                         input bit neg, input int periods);
        stim = s; neg_mode = neg;
        repeat (3) step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < zeros; i++) sclk_bit(1'b0);
        sclk_bit(1'b1);
        for (int i = 3; i >= 0; i--) sclk_bit(w[i]);
        chk(assign_word, w, "R2 start found after leading zeros");
        for (int i = 0; i < periods; i++) sclk_bit(i[0] ^ i[2]);
        chk(assign_word, w, "R4 word unaffected by DI during conversion");
        if (periods >= 16) begin
            chk(do_data, 1'b0, "R8 held low after both streams");
            chk(busy, 1'b0, "R7 busy low after conversion");
        end
        repeat (3) step(1'b1, 1'b0, 1'b0);
        chk(do_oe, 1'b0, "R1 released after deselect");
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) step(1'b1, 1'b0, 1'b0);
        chk(do_oe | busy_oe | word_vld, 1'b0, "R1 reset state");
        frame(0, 4'b1010, 8'hA5, 1'b0, 18);
        frame(3, 4'b0110, 8'h00, 1'b0, 18);
        frame(1, 4'b1111, 8'hFF, 1'b0, 18);
        frame(5, 4'b0001, 8'h3C, 1'b1, 18);
        frame(2, 4'b1100, 8'h81, 1'b0, 5);   // aborted mid-conversion
        frame(0, 4'b0011, 8'h7E, 1'b0, 20);  // clean frame after abort
        frame(7, 4'b1001, 8'h01, 1'b0, 18);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule